// File: doc/BRIEF.md
# Snooping Coherent Bus Router

This block joins several cache-side ports to a single memory-side port. Requests from the cache side are arbitrated round-robin and passed down to memory with a tag that records which port sent them. A request to a cacheable address is also sent as a snoop to every other cache-side port. Responses from memory go back to the port named by their tag. Snoop requests raised by the memory side go out to every cache-side port. Snoop replies return to whichever side raised the snoop.

The block has a busy window. Certain transfers start it, and it then lasts a programmable number of cycles. While busy, the bus refuses three kinds of traffic: new cache-side requests, memory responses and memory-side snoops. Snoop replies from the caches are always taken.

A cache that answers a snoop with its own data marks the reply as inhibiting. The bus then tells memory to cancel the originator's request, and it quietly consumes the next memory response for that originator.

Tags are 0 to N-1 for the cache-side ports. The value N stands for the memory side.

Top module: `cbus_router`

## Requirements
- R1: When the bus is not busy and no memory-side snoop is offered, one valid cache-side request is accepted in the same cycle (one-hot `upReqReady`). In that cycle `dnReqValid` is 1 and `dnReqAddr`, `dnReqWrite` and `dnReqSrc` carry the winner's address, write flag and port index.
- R2: An accepted request with `upReqCacheable`=1 drives `snpValid` to 1 on every other cache-side port, with `snpAddr` set to its address and `snpSrc` set to its port index. The requester is never snooped. A non-cacheable request drives no snoop.
- R3: Arbitration is round-robin. After port i wins, the search starts at port i+1 and wraps around. After reset, port 0 has first priority.
- R4: A memory response accepted with tag d (d < N), when no inhibit is pending for d, sets `upRspValid[d]` alone and drives `upRspData` with the response data.
- R5: A memory-side snoop accepted while not busy sets all bits of `snpValid`, with `snpSrc`=N and `snpAddr` set to its address. No cache-side request is accepted in that cycle.
- R6: A snoop reply whose destination tag is N raises `dnSnpRspValid`, and `dnSnpRspInhibit` is the OR of the inhibit flags of those replies. A reply whose tag is d < N raises `snpDelValid[d]`, and `snpDelInhibit[d]` carries its inhibit flag.
- R7: The following events each start the busy window: a snoop sent to a cache-side port, a response delivered to a cache-side port, a snoop reply routed to a cache-side port, or a snoop reply routed to memory. For the next BUSY_CYCLES cycles after any of them, `upReqReady`, `dnRspReady` and `dnSnpReady` are all 0. Snoop replies are still routed during the window.
- R8: A non-cacheable request and a consumed (inhibited) response do not start the busy window, so the ready outputs stay 1 in the next cycle.
- R9: A snoop reply to cache-side port d with inhibit set pulses `dnCancelValid` with `dnCancelSrc`=d in the same cycle. The next memory response tagged d is accepted but delivered nowhere. The one after it is delivered normally.
- R10: After reset the bus is not busy (all ready outputs are 1), no inhibit is pending, and every output valid is 0 when no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upReqValid | input | N | Request offered per cache-side port |
| upReqAddr | input | N*AW | Request address per port |
| upReqWrite | input | N | Request is a write, per port |
| upReqCacheable | input | N | Request targets cacheable memory, per port |
| upReqReady | output | N | Request accepted this cycle (one-hot) |
| dnReqValid | output | 1 | Request forwarded to memory |
| dnReqAddr | output | AW | Forwarded address |
| dnReqWrite | output | 1 | Forwarded write flag |
| dnReqSrc | output | TW | Tag of the requesting port |
| dnRspValid | input | 1 | Memory response offered |
| dnRspSrc | input | TW | Response destination tag |
| dnRspData | input | DW | Response data |
| dnRspReady | output | 1 | Memory response accepted |
| upRspValid | output | N | Response delivered per cache-side port |
| upRspData | output | DW | Delivered response data |
| dnSnpValid | input | 1 | Snoop offered by memory side |
| dnSnpAddr | input | AW | Memory-side snoop address |
| dnSnpReady | output | 1 | Memory-side snoop accepted |
| snpValid | output | N | Snoop issued per cache-side port |
| snpAddr | output | AW | Snoop address |
| snpSrc | output | TW | Tag of the snoop originator |
| upSnpRspValid | input | N | Snoop reply per cache-side port |
| upSnpRspDest | input | N*TW | Destination tag of each snoop reply |
| upSnpRspInhibit | input | N | Replying cache supplies the data |
| snpDelValid | output | N | Snoop reply delivered per cache-side port |
| snpDelInhibit | output | N | Inhibit flag of the delivered reply |
| dnSnpRspValid | output | 1 | Snoop reply delivered to memory side |
| dnSnpRspInhibit | output | 1 | Inhibit flag of that reply |
| dnCancelValid | output | 1 | Memory must drop the request of dnCancelSrc |
| dnCancelSrc | output | TW | Originator whose request is cancelled |

## Verification
The checker tests several properties on every cycle. It checks that grants are one-hot and match the forwarded request, and that no port snoops itself. It checks that responses appear only when a memory response is accepted, and that a memory-side snoop blocks cache-side grants. It keeps its own count of the busy window from the events it sees at the ports, and checks that the ready outputs fall and rise with that count.

Some behaviour only the directed scenarios can show. These include the round-robin order over several cycles, delivery of responses to the correct tag, and the exact length of the busy window. They also include the inhibit sequence: a cancel pulse, then one swallowed response, then a normal one.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef struct packed {
    logic fwdReq;      // a cache-side request is forwarded this cycle
    logic snpUp;       // that request is snooped to the other ports
    logic snpDn;       // memory-side snoop is broadcast this cycle
    logic rspDeliver;  // memory response goes to a cache-side port
    logic rspDrop;     // memory response is consumed due to inhibit
  } cbusStrobe_t;
endpackage

// File: rtl/cbus_ctrl.sv
module cbus_ctrl
  import cbus_pkg::*;
#(
  parameter int N = 3,
  parameter int BUSY_CYCLES = 3,
  localparam int TW = $clog2(N + 1),
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  upReqValid,
  input  logic [N-1:0]  upReqCacheable,
  input  logic          dnRspValid,
  input  logic [TW-1:0] dnRspSrc,
  input  logic          dnSnpValid,
  input  logic [N-1:0]  snpRouteUp,
  input  logic [N-1:0]  snpRouteInhibit,
  input  logic          snpToDn,
  output cbusStrobe_t   strobe,
  output logic [IW-1:0] grantIdx,
  output logic [N-1:0]  upReqReady,
  output logic          dnRspReady,
  output logic          dnSnpReady
);
  logic [CW-1:0] busyCnt;
  logic [IW-1:0] rrPtr;
  logic [N-1:0]  inhibitPend;
  logic          busy, anyReq, reqWindow, rspAcc, rspSrcOk, trigger;

  assign busy       = (busyCnt != '0);
  assign dnSnpReady = !busy;
  assign dnRspReady = !busy;
  assign reqWindow  = !busy && !dnSnpValid;

  always_comb begin
    int c;
    grantIdx = '0;
    anyReq   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = int'(rrPtr) + k;
      if (c >= N) c = c - N;
      if (!anyReq && upReqValid[c]) begin
        anyReq   = 1'b1;
        grantIdx = IW'(c);
      end
    end
  end

  assign rspSrcOk = (int'(dnRspSrc) < N);
  assign rspAcc   = dnRspValid && !busy && rspSrcOk;

  always_comb begin
    strobe            = '0;
    strobe.fwdReq     = reqWindow && anyReq;
    strobe.snpUp      = strobe.fwdReq && upReqCacheable[grantIdx] && (N > 1);
    strobe.snpDn      = dnSnpValid && !busy;
    strobe.rspDrop    = rspAcc && inhibitPend[IW'(dnRspSrc)];
    strobe.rspDeliver = rspAcc && !inhibitPend[IW'(dnRspSrc)];
  end

  always_comb begin
    upReqReady = '0;
    if (strobe.fwdReq) upReqReady[grantIdx] = 1'b1;
  end

  assign trigger = strobe.snpUp || strobe.snpDn || strobe.rspDeliver ||
                   (|snpRouteUp) || snpToDn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
      rrPtr   <= IW'(N - 1);
    end else begin
      if (trigger)   busyCnt <= CW'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      if (strobe.fwdReq) rrPtr <= grantIdx;
    end
  end

  for (genvar d = 0; d < N; d++) begin : g_inh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inhibitPend[d] <= 1'b0;
      else if (snpRouteUp[d] && snpRouteInhibit[d]) inhibitPend[d] <= 1'b1;
      else if (strobe.rspDrop && dnRspSrc == TW'(d)) inhibitPend[d] <= 1'b0;
    end
  end
endmodule

// File: rtl/cbus_dpath.sv
module cbus_dpath
  import cbus_pkg::*;
#(
  parameter int N = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int TW = $clog2(N + 1),
  localparam int IW = $clog2(N)
) (
  input  cbusStrobe_t     strobe,
  input  logic [IW-1:0]   grantIdx,
  input  logic [N*AW-1:0] upReqAddr,
  input  logic [N-1:0]    upReqWrite,
  input  logic [TW-1:0]   dnRspSrc,
  input  logic [DW-1:0]   dnRspData,
  input  logic [AW-1:0]   dnSnpAddr,
  input  logic [N-1:0]    upSnpRspValid,
  input  logic [N*TW-1:0] upSnpRspDest,
  input  logic [N-1:0]    upSnpRspInhibit,
  output logic            dnReqValid,
  output logic [AW-1:0]   dnReqAddr,
  output logic            dnReqWrite,
  output logic [TW-1:0]   dnReqSrc,
  output logic [N-1:0]    upRspValid,
  output logic [DW-1:0]   upRspData,
  output logic [N-1:0]    snpValid,
  output logic [AW-1:0]   snpAddr,
  output logic [TW-1:0]   snpSrc,
  output logic [N-1:0]    snpDelValid,
  output logic [N-1:0]    snpDelInhibit,
  output logic            dnSnpRspValid,
  output logic            dnSnpRspInhibit,
  output logic            dnCancelValid,
  output logic [TW-1:0]   dnCancelSrc
);
  logic [AW-1:0] grantAddr;

  assign grantAddr  = upReqAddr[grantIdx*AW +: AW];
  assign dnReqValid = strobe.fwdReq;
  assign dnReqAddr  = grantAddr;
  assign dnReqWrite = upReqWrite[grantIdx];
  assign dnReqSrc   = TW'(grantIdx);
  assign upRspData  = dnRspData;

  always_comb begin
    snpValid = '0;
    snpAddr  = '0;
    snpSrc   = '0;
    if (strobe.snpDn) begin
      snpValid = '1;
      snpAddr  = dnSnpAddr;
      snpSrc   = TW'(N);
    end else if (strobe.snpUp) begin
      snpValid = '1;
      snpValid[grantIdx] = 1'b0;
      snpAddr  = grantAddr;
      snpSrc   = TW'(grantIdx);
    end
  end

  for (genvar d = 0; d < N; d++) begin : g_rsp
    assign upRspValid[d] = strobe.rspDeliver && (dnRspSrc == TW'(d));
  end

  always_comb begin
    snpDelValid     = '0;
    snpDelInhibit   = '0;
    dnSnpRspValid   = 1'b0;
    dnSnpRspInhibit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (upSnpRspValid[i]) begin
        if (upSnpRspDest[i*TW +: TW] == TW'(N)) begin
          dnSnpRspValid   = 1'b1;
          dnSnpRspInhibit = dnSnpRspInhibit | upSnpRspInhibit[i];
        end
        for (int d = 0; d < N; d++) begin
          if (upSnpRspDest[i*TW +: TW] == TW'(d)) begin
            snpDelValid[d]   = 1'b1;
            snpDelInhibit[d] = snpDelInhibit[d] | upSnpRspInhibit[i];
          end
        end
      end
    end
  end

  always_comb begin
    dnCancelValid = 1'b0;
    dnCancelSrc   = '0;
    for (int d = N - 1; d >= 0; d--) begin
      if (snpDelValid[d] && snpDelInhibit[d]) begin
        dnCancelValid = 1'b1;
        dnCancelSrc   = TW'(d);
      end
    end
  end
endmodule

// File: rtl/cbus_router.sv
module cbus_router
  import cbus_pkg::*;
#(
  parameter int N = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BUSY_CYCLES = 3,
  localparam int TW = $clog2(N + 1),
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    upReqValid,
  input  logic [N*AW-1:0] upReqAddr,
  input  logic [N-1:0]    upReqWrite,
  input  logic [N-1:0]    upReqCacheable,
  output logic [N-1:0]    upReqReady,
  output logic            dnReqValid,
  output logic [AW-1:0]   dnReqAddr,
  output logic            dnReqWrite,
  output logic [TW-1:0]   dnReqSrc,
  input  logic            dnRspValid,
  input  logic [TW-1:0]   dnRspSrc,
  input  logic [DW-1:0]   dnRspData,
  output logic            dnRspReady,
  output logic [N-1:0]    upRspValid,
  output logic [DW-1:0]   upRspData,
  input  logic            dnSnpValid,
  input  logic [AW-1:0]   dnSnpAddr,
  output logic            dnSnpReady,
  output logic [N-1:0]    snpValid,
  output logic [AW-1:0]   snpAddr,
  output logic [TW-1:0]   snpSrc,
  input  logic [N-1:0]    upSnpRspValid,
  input  logic [N*TW-1:0] upSnpRspDest,
  input  logic [N-1:0]    upSnpRspInhibit,
  output logic [N-1:0]    snpDelValid,
  output logic [N-1:0]    snpDelInhibit,
  output logic            dnSnpRspValid,
  output logic            dnSnpRspInhibit,
  output logic            dnCancelValid,
  output logic [TW-1:0]   dnCancelSrc
);
  cbusStrobe_t   strobe;
  logic [IW-1:0] grantIdx;

  cbus_ctrl #(.N(N), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .upReqValid(upReqValid), .upReqCacheable(upReqCacheable),
    .dnRspValid(dnRspValid), .dnRspSrc(dnRspSrc), .dnSnpValid(dnSnpValid),
    .snpRouteUp(snpDelValid), .snpRouteInhibit(snpDelInhibit),
    .snpToDn(dnSnpRspValid),
    .strobe(strobe), .grantIdx(grantIdx), .upReqReady(upReqReady),
    .dnRspReady(dnRspReady), .dnSnpReady(dnSnpReady)
  );

  cbus_dpath #(.N(N), .AW(AW), .DW(DW)) u_dpath (
    .strobe(strobe), .grantIdx(grantIdx),
    .upReqAddr(upReqAddr), .upReqWrite(upReqWrite),
    .dnRspSrc(dnRspSrc), .dnRspData(dnRspData), .dnSnpAddr(dnSnpAddr),
    .upSnpRspValid(upSnpRspValid), .upSnpRspDest(upSnpRspDest),
    .upSnpRspInhibit(upSnpRspInhibit),
    .dnReqValid(dnReqValid), .dnReqAddr(dnReqAddr), .dnReqWrite(dnReqWrite),
    .dnReqSrc(dnReqSrc), .upRspValid(upRspValid), .upRspData(upRspData),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpSrc(snpSrc),
    .snpDelValid(snpDelValid), .snpDelInhibit(snpDelInhibit),
    .dnSnpRspValid(dnSnpRspValid), .dnSnpRspInhibit(dnSnpRspInhibit),
    .dnCancelValid(dnCancelValid), .dnCancelSrc(dnCancelSrc)
  );
endmodule

// File: rtl/cbus_router_chk.sv
module cbus_router_chk #(
  parameter int N = 3,
  parameter int BUSY_CYCLES = 3,
  localparam int TW = $clog2(N + 1),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  upReqReady,
  input logic          dnReqValid,
  input logic          dnRspValid,
  input logic          dnRspReady,
  input logic [N-1:0]  upRspValid,
  input logic          dnSnpValid,
  input logic          dnSnpReady,
  input logic [N-1:0]  snpValid,
  input logic [TW-1:0] snpSrc,
  input logic [N-1:0]  upSnpRspInhibit,
  input logic [N-1:0]  snpDelValid,
  input logic          dnSnpRspValid,
  input logic          dnCancelValid
);
  logic [CW-1:0] winCnt;
  logic          portEvent;

  assign portEvent = (|snpValid) || (|upRspValid) || (|snpDelValid) || dnSnpRspValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) winCnt <= '0;
    else if (portEvent) winCnt <= CW'(BUSY_CYCLES);
    else if (winCnt != '0) winCnt <= winCnt - 1'b1;
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upReqReady));
  assert_fwd_matches_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dnReqValid == (|upReqReady));
  for (genvar i = 0; i < N; i++) begin : g_self
    assert_no_self_snoop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      snpValid[i] |-> (snpSrc != TW'(i)));
  end
  assert_rsp_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|upRspValid) |-> (dnRspValid && dnRspReady && $onehot(upRspValid)));
  assert_dn_snoop_blocks_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dnSnpValid && dnSnpReady) |-> (upReqReady == '0));
  assert_busy_rejects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (winCnt != '0) |-> (!dnRspReady && !dnSnpReady && upReqReady == '0));
  assert_idle_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (winCnt == '0) |-> (dnRspReady && dnSnpReady));
  assert_cancel_has_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dnCancelValid |-> (|upSnpRspInhibit));
endmodule

bind cbus_router cbus_router_chk #(.N(N), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .upReqReady(upReqReady), .dnReqValid(dnReqValid),
  .dnRspValid(dnRspValid), .dnRspReady(dnRspReady), .upRspValid(upRspValid),
  .dnSnpValid(dnSnpValid), .dnSnpReady(dnSnpReady), .snpValid(snpValid),
  .snpSrc(snpSrc), .upSnpRspInhibit(upSnpRspInhibit), .snpDelValid(snpDelValid),
  .dnSnpRspValid(dnSnpRspValid), .dnCancelValid(dnCancelValid)
);

// File: tb/cbus_router_bench.sv
`timescale 1ns/1ps
module cbus_router_bench;
  localparam int N = 3, AW = 16, DW = 16, BC = 3, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] upReqValid, upReqWrite, upReqCacheable, upReqReady;
  logic [N*AW-1:0] upReqAddr;
  logic dnReqValid, dnReqWrite, dnRspValid, dnRspReady, dnSnpValid, dnSnpReady;
  logic [AW-1:0] dnReqAddr, dnSnpAddr, snpAddr;
  logic [TW-1:0] dnReqSrc, dnRspSrc, snpSrc, dnCancelSrc;
  logic [DW-1:0] dnRspData, upRspData;
  logic [N-1:0] upRspValid, snpValid, upSnpRspValid, upSnpRspInhibit, snpDelValid, snpDelInhibit;
  logic [N*TW-1:0] upSnpRspDest;
  logic dnSnpRspValid, dnSnpRspInhibit, dnCancelValid;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  cbus_router #(.N(N), .AW(AW), .DW(DW), .BUSY_CYCLES(BC)) u_cbus_router (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    upReqValid = '0; upReqWrite = '0; upReqCacheable = '0; upReqAddr = '0;
    dnRspValid = 0; dnRspSrc = '0; dnRspData = '0; dnSnpValid = 0; dnSnpAddr = '0;
    upSnpRspValid = '0; upSnpRspDest = '0; upSnpRspInhibit = '0;
  endtask

  task automatic doReset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic readyIs(input bit exp, input string req);
    int act = {31'd0, dnRspReady} + {31'd0, dnSnpReady};
    chk(dnRspReady == exp && dnSnpReady == exp, req, "readies", act, exp ? 2 : 0);
  endtask

  // Clears inputs, then checks BC busy cycles and the free cycle after them.
  task automatic busyWindow(input string req);
    for (int c = 0; c < BC; c++) begin
      @(negedge clk); idle(); upReqValid = 3'b001; #1;
      readyIs(0, req);
      chk(upReqReady == 0, req, "req blocked while busy", upReqReady, 0);
    end
    @(negedge clk); idle(); #1;
    readyIs(1, req);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    readyIs(1, "R10");
    chk(dnReqValid == 0 && upRspValid == 0 && snpValid == 0 && dnCancelValid == 0,
        "R10", "outputs idle", {dnReqValid, upRspValid, snpValid}, 0);
  endtask

  task automatic testUncached();
    @(negedge clk); idle();
    upReqValid = 3'b100; upReqWrite = 3'b100; upReqAddr[2*AW +: AW] = 16'hBEE0; #1;
    chk(upReqReady == 3'b100, "R1", "grant", upReqReady, 3'b100);
    chk(dnReqValid && dnReqAddr == 16'hBEE0 && dnReqWrite && dnReqSrc == 2,
        "R1", "forwarded addr", dnReqAddr, 16'hBEE0);
    chk(snpValid == 0, "R2", "no snoop for uncached", snpValid, 0);
    @(negedge clk); idle(); #1;
    readyIs(1, "R8");
  endtask

  task automatic testCached();
    @(negedge clk); idle();
    upReqValid = 3'b010; upReqCacheable = 3'b010; upReqAddr[AW +: AW] = 16'h1234; #1;
    chk(upReqReady == 3'b010 && dnReqSrc == 1, "R1", "cached grant", upReqReady, 3'b010);
    chk(snpValid == 3'b101, "R2", "snoop targets", snpValid, 3'b101);
    chk(snpSrc == 1 && snpAddr == 16'h1234, "R2", "snoop src/addr", snpAddr, 16'h1234);
    busyWindow("R7");
  endtask

  task automatic testRoundRobin();
    int exp[4] = '{1, 2, 4, 1};
    doReset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle(); upReqValid = 3'b111; #1;
      chk(upReqReady == exp[k][2:0], "R3", "rr grant all", upReqReady, exp[k]);
    end
    @(negedge clk); idle(); upReqValid = 3'b101; #1;
    chk(upReqReady == 3'b100, "R3", "rr skip idle", upReqReady, 3'b100);
    @(negedge clk); idle(); upReqValid = 3'b101; #1;
    chk(upReqReady == 3'b001, "R3", "rr wrap", upReqReady, 3'b001);
  endtask

  task automatic testResponse();
    @(negedge clk); idle();
    dnRspValid = 1; dnRspSrc = 2'd1; dnRspData = 16'hCAFE; #1;
    chk(dnRspReady && upRspValid == 3'b010, "R4", "deliver", upRspValid, 3'b010);
    chk(upRspData == 16'hCAFE, "R4", "data", upRspData, 16'hCAFE);
    busyWindow("R7");
  endtask

  task automatic testDnSnoop();
    @(negedge clk); idle();
    dnSnpValid = 1; dnSnpAddr = 16'h0F0F; upReqValid = 3'b001; #1;
    chk(dnSnpReady && snpValid == 3'b111, "R5", "broadcast", snpValid, 3'b111);
    chk(snpSrc == 3 && snpAddr == 16'h0F0F, "R5", "snoop src", snpSrc, 3);
    chk(upReqReady == 0, "R5", "req held off", upReqReady, 0);
    busyWindow("R7");
  endtask

  task automatic testSnoopReplies();
    @(negedge clk); idle();
    upSnpRspValid = 3'b011; upSnpRspDest = {2'd0, 2'd3, 2'd3}; upSnpRspInhibit = 3'b010; #1;
    chk(dnSnpRspValid && dnSnpRspInhibit, "R6", "reply to memory", dnSnpRspInhibit, 1);
    chk(snpDelValid == 0, "R6", "no upstream delivery", snpDelValid, 0);
    // reply during busy window still routed upstream
    @(negedge clk); idle();
    upSnpRspValid = 3'b100; upSnpRspDest = {2'd0, 2'd0, 2'd0}; #1;
    readyIs(0, "R7");
    chk(snpDelValid == 3'b001 && snpDelInhibit == 0, "R6", "reply to port0", snpDelValid, 3'b001);
    busyWindow("R7");
  endtask

  task automatic testInhibit();
    @(negedge clk); idle();
    upSnpRspValid = 3'b001; upSnpRspDest = {2'd0, 2'd0, 2'd1}; upSnpRspInhibit = 3'b001; #1;
    chk(snpDelValid == 3'b010 && snpDelInhibit == 3'b010, "R6", "inhibit reply", snpDelInhibit, 3'b010);
    chk(dnCancelValid && dnCancelSrc == 1, "R9", "cancel", dnCancelSrc, 1);
    busyWindow("R7");
    @(negedge clk); idle(); dnRspValid = 1; dnRspSrc = 2'd1; dnRspData = 16'h1111; #1;
    chk(dnRspReady && upRspValid == 0, "R9", "consumed", upRspValid, 0);
    @(negedge clk); idle(); dnRspValid = 1; dnRspSrc = 2'd1; dnRspData = 16'h2222; #1;
    readyIs(1, "R8");
    chk(upRspValid == 3'b010 && upRspData == 16'h2222, "R9", "next delivered", upRspValid, 3'b010);
    busyWindow("R7");
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    doReset();
    testReset();
    testUncached();
    testCached();
    testRoundRobin();
    testResponse();
    testDnSnoop();
    testSnoopReplies();
    testInhibit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule